// File: doc/BRIEF.md
# Serial Channel Interrupt Request Unit

This block works out the interrupt request for each channel of a multi-channel serial communications controller. Each channel keeps two pending flags, one for receive and one for transmit. Single-cycle event strobes set the flags, and software-issued reset commands clear them. Every cycle the block combines these flags with the channel's interrupt-enable register, its extended-enable register and its status register, and forms a registered, active-high, level request for that channel.

There are three sources of interrupt. The transmit source and the break source each have their own enable bit. The receive source counts as enabled only under two of the four receive-interrupt mode codes. A master enable bit gates all three sources. The per-channel requests are ORed together onto one shared interrupt line.

The surrounding register file owns the configuration registers and the break status bit, and feeds them into this block. The block produces no interrupt vector and no priority chain.

Top module: `scc_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first sampling point after it is released with no events, every `ch_irq` bit and `irq_shared` are 0.
- R2: If master enable bit 0 of a channel's enable register (`wr1`) is 0, that channel's `ch_irq` is 0 whatever its flags and status.
- R3: The transmit source raises the request when `wr1` bit 1 is 1 and the transmit pending flag is set.
- R4: The receive source raises the request when `wr1` bits 4:3 are 2'b01 or 2'b10 and the receive pending flag is set. The codes 2'b00 and 2'b11 never let the receive flag raise a request.
- R5: The break source raises the request when bit 7 of the extended-enable register (`wr15`) and bit 7 of the status register (`rr0`) are both 1. It does not depend on the pending flags.
- R6: A `rx_accept` pulse sets the receive pending flag, and `rx_int_clr` clears it. A `tx_write` pulse sets the transmit pending flag, and `tx_int_clr` clears it.
- R7: When a set event and the matching clear command for one flag arrive in the same cycle, the flag ends up set.
- R8: A `ch_reset` pulse clears both pending flags of that channel and drives its `ch_irq` to 0 at that same clock edge.
- R9: `irq_shared` is 1 exactly when at least one `ch_irq` bit is 1.
- R10: `ch_irq` is registered. A flag set at clock edge k shows on `ch_irq` after edge k+1. A change of `wr1`, `wr15` or `rr0` shows after the next edge.
- R11: Channels are independent. Events, resets and registers of one channel never affect another channel's `ch_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_reset | input | NUM_CH | Per-channel synchronous reset of the pending flags and the request |
| wr1 | input | NUM_CH*8 | Interrupt-enable register per channel (bit 0 master, bit 1 transmit, bits 4:3 receive mode) |
| wr15 | input | NUM_CH*8 | Extended-enable register per channel (bit 7 break enable) |
| rr0 | input | NUM_CH*8 | Status register per channel (bit 7 break detected) |
| rx_accept | input | NUM_CH | Received byte accepted strobe |
| tx_write | input | NUM_CH | Transmit data write accepted strobe |
| rx_int_clr | input | NUM_CH | Reset-receive-interrupt command strobe |
| tx_int_clr | input | NUM_CH | Reset-transmit-interrupt command strobe |
| ch_irq | output | NUM_CH | Registered level request per channel |
| irq_shared | output | 1 | OR of all channel requests |

## Verification
A pending flag with the wrong value appears on `ch_irq` two clock edges after the strobe that should have changed it. That delay is one edge for the flag and one for the request register. It can only be seen while the matching source is enabled. For that reason, every flag check uses an enable setting under which the flag alone sets the outcome. A wrong decode of the enable or status bits appears one edge after the register changes. A missed channel reset appears on the edge right after the reset pulse, as a request that stays high.

// File: rtl/scc_irq_pkg.sv
package scc_irq_pkg;
  localparam int REG_W      = 8;
  localparam int MIE_BIT    = 0;
  localparam int TXIE_BIT   = 1;
  localparam int RXM_LO     = 3;
  localparam int BRK_EN_BIT = 7;
  localparam int BRK_ST_BIT = 7;

  // Receive interrupts count only for modes 01 and 10
  function automatic logic rx_mode_on(input logic [1:0] mode);
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction

  function automatic logic irq_eval(input logic [REG_W-1:0] en1,
                                    input logic [REG_W-1:0] en15,
                                    input logic [REG_W-1:0] stat,
                                    input logic             rx_p,
                                    input logic             tx_p);
    logic tx_src, rx_src, brk_src;
    tx_src  = en1[TXIE_BIT] && tx_p;
    rx_src  = rx_mode_on(en1[RXM_LO+1:RXM_LO]) && rx_p;
    brk_src = en15[BRK_EN_BIT] && stat[BRK_ST_BIT];
    return en1[MIE_BIT] && (tx_src || rx_src || brk_src);
  endfunction
endpackage

// File: rtl/irq_pend_flag.sv
module irq_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic set_ev,
  input  logic clr_cmd,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (clr_all) q <= 1'b0;
    else if (set_ev)  q <= 1'b1;
    else if (clr_cmd) q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && !clr_all) |=> q); // R7
  AST_CLR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && !set_ev) |=> !q); // R6
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !q); // R8
endmodule

// File: rtl/scc_irq_chan.sv
module scc_irq_chan
  import scc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_reset,
  input  logic [REG_W-1:0] wr1,
  input  logic [REG_W-1:0] wr15,
  input  logic [REG_W-1:0] rr0,
  input  logic             rx_accept,
  input  logic             tx_write,
  input  logic             rx_int_clr,
  input  logic             tx_int_clr,
  output logic             irq
);
  logic rx_pend, tx_pend, irq_next;

  irq_pend_flag u_rx_flag (
    .clk(clk), .rst_n(rst_n), .clr_all(ch_reset),
    .set_ev(rx_accept), .clr_cmd(rx_int_clr), .q(rx_pend));

  irq_pend_flag u_tx_flag (
    .clk(clk), .rst_n(rst_n), .clr_all(ch_reset),
    .set_ev(tx_write), .clr_cmd(tx_int_clr), .q(tx_pend));

  assign irq_next = irq_eval(wr1, wr15, rr0, rx_pend, tx_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (ch_reset) irq <= 1'b0;
    else               irq <= irq_next;
  end

  AST_NO_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    !wr1[MIE_BIT] |=> !irq); // R2
  AST_TX_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1[MIE_BIT] && wr1[TXIE_BIT] && tx_pend && !ch_reset) |=> irq); // R3
  AST_BRK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1[MIE_BIT] && wr15[BRK_EN_BIT] && rr0[BRK_ST_BIT] && !ch_reset) |=> irq); // R5
  AST_RESET_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ch_reset |=> !irq); // R8
endmodule

// File: rtl/scc_irq_ctrl.sv
module scc_irq_ctrl
  import scc_irq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       ch_reset,
  input  logic [NUM_CH*REG_W-1:0] wr1,
  input  logic [NUM_CH*REG_W-1:0] wr15,
  input  logic [NUM_CH*REG_W-1:0] rr0,
  input  logic [NUM_CH-1:0]       rx_accept,
  input  logic [NUM_CH-1:0]       tx_write,
  input  logic [NUM_CH-1:0]       rx_int_clr,
  input  logic [NUM_CH-1:0]       tx_int_clr,
  output logic [NUM_CH-1:0]       ch_irq,
  output logic                    irq_shared
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    scc_irq_chan u_chan (
      .clk(clk), .rst_n(rst_n), .ch_reset(ch_reset[c]),
      .wr1(wr1[c*REG_W +: REG_W]),
      .wr15(wr15[c*REG_W +: REG_W]),
      .rr0(rr0[c*REG_W +: REG_W]),
      .rx_accept(rx_accept[c]), .tx_write(tx_write[c]),
      .rx_int_clr(rx_int_clr[c]), .tx_int_clr(tx_int_clr[c]),
      .irq(ch_irq[c]));
  end

  assign irq_shared = |ch_irq;

  AST_SHARED_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (&ch_reset) |=> !irq_shared); // R9
endmodule

// File: tb/tb_scc_irq_ctrl.sv
module tb_scc_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  // {wr1[7:0], wr15[7:0], rr0[7:0], rx pending, tx pending, expected}
  localparam int NVEC = 15;
  localparam logic [26:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0},  // R2 no master
    {8'h02, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0},  // R2 tx enabled, master off
    {8'h03, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1},  // R3
    {8'h01, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0},  // R3 tx enable off
    {8'h09, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1},  // R4 mode 01
    {8'h11, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1},  // R4 mode 10
    {8'h01, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},  // R4 mode 00
    {8'h19, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},  // R4 mode 11
    {8'h09, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0},  // R3 tx pending but disabled
    {8'h01, 8'h80, 8'h80, 1'b0, 1'b0, 1'b1},  // R5
    {8'h01, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0},  // R5 no status
    {8'h01, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0},  // R5 no enable
    {8'h00, 8'h80, 8'h80, 1'b0, 1'b0, 1'b0},  // R2 break, master off
    {8'h1B, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},  // R4 mode 11 with tx enable
    {8'h1B, 8'h7F, 8'h7F, 1'b1, 1'b1, 1'b1}   // R3 tx wins, break bits off
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]   ch_reset = '0, rx_accept = '0, tx_write = '0;
  logic [NCH-1:0]   rx_int_clr = '0, tx_int_clr = '0;
  logic [NCH*8-1:0] wr1 = '0, wr15 = '0, rr0 = '0;
  logic [NCH-1:0]   ch_irq;
  logic             irq_shared;
  int errors = 0, checks = 0;

  scc_irq_ctrl #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .ch_reset(ch_reset), .wr1(wr1), .wr15(wr15),
    .rr0(rr0), .rx_accept(rx_accept), .tx_write(tx_write),
    .rx_int_clr(rx_int_clr), .tx_int_clr(tx_int_clr),
    .ch_irq(ch_irq), .irq_shared(irq_shared));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic reset_ch0();
    ch_reset[0] = 1'b1; nx(); ch_reset[0] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2);
    chk("R1 reset ch_irq0", ch_irq[0], 1'b0);
    chk("R1 reset shared", irq_shared, 1'b0);
    nx(); rst_n = 1'b1; nx(); nx();
    chk("R1 after release", irq_shared, 1'b0);

    // table walk on channel 0
    for (int i = 0; i < NVEC; i++) begin
      wr1[7:0] = 8'h00; wr15[7:0] = 8'h00; rr0[7:0] = 8'h00;
      reset_ch0();
      wr1[7:0] = VEC[i][26:19]; wr15[7:0] = VEC[i][18:11]; rr0[7:0] = VEC[i][10:3];
      rx_accept[0] = VEC[i][2]; tx_write[0] = VEC[i][1];
      nx(); rx_accept[0] = 1'b0; tx_write[0] = 1'b0;
      nx();
      chk($sformatf("R2-5 vec%0d ch_irq0", i), ch_irq[0], VEC[i][0]);
      chk($sformatf("R9 vec%0d shared", i), irq_shared, VEC[i][0]);
      chk($sformatf("R11 vec%0d ch_irq1", i), ch_irq[1], 1'b0);
    end

    // R10 latency and R6 clears, receive path
    wr1[7:0] = 8'h00; wr15[7:0] = 8'h00; rr0[7:0] = 8'h00;
    reset_ch0();
    wr1[7:0] = 8'h09; nx();
    rx_accept[0] = 1'b1; nx(); rx_accept[0] = 1'b0;
    chk("R10 not yet", ch_irq[0], 1'b0);
    nx();
    chk("R10 one edge later", ch_irq[0], 1'b1);
    rx_int_clr[0] = 1'b1; nx(); rx_int_clr[0] = 1'b0; nx();
    chk("R6 rx clear", ch_irq[0], 1'b0);

    // R6 transmit clear
    wr1[7:0] = 8'h03;
    tx_write[0] = 1'b1; nx(); tx_write[0] = 1'b0; nx();
    chk("R6 tx set", ch_irq[0], 1'b1);
    tx_int_clr[0] = 1'b1; nx(); tx_int_clr[0] = 1'b0; nx();
    chk("R6 tx clear", ch_irq[0], 1'b0);

    // R7 set wins over clear
    wr1[7:0] = 8'h09;
    rx_accept[0] = 1'b1; rx_int_clr[0] = 1'b1; nx();
    rx_accept[0] = 1'b0; rx_int_clr[0] = 1'b0; nx();
    chk("R7 rx set wins", ch_irq[0], 1'b1);
    wr1[7:0] = 8'h03; reset_ch0(); nx();
    tx_write[0] = 1'b1; tx_int_clr[0] = 1'b1; nx();
    tx_write[0] = 1'b0; tx_int_clr[0] = 1'b0; nx();
    chk("R7 tx set wins", ch_irq[0], 1'b1);

    // R8 channel reset drops request at once and clears flags
    wr1[7:0] = 8'h1B;
    rx_accept[0] = 1'b1; nx(); rx_accept[0] = 1'b0; nx();
    wr1[7:0] = 8'h0B; nx();
    chk("R8 pre-reset", ch_irq[0], 1'b1);
    ch_reset[0] = 1'b1; nx(); ch_reset[0] = 1'b0;
    chk("R8 drop at reset edge", ch_irq[0], 1'b0);
    nx(); nx();
    chk("R8 flags cleared", ch_irq[0], 1'b0);

    // R11 channel 1 alone, R9 shared
    wr1[15:8] = 8'h03;
    tx_write[1] = 1'b1; nx(); tx_write[1] = 1'b0; nx();
    chk("R11 ch1 raised", ch_irq[1], 1'b1);
    chk("R11 ch0 untouched", ch_irq[0], 1'b0);
    chk("R9 shared from ch1", irq_shared, 1'b1);
    ch_reset[1] = 1'b1; nx(); ch_reset[1] = 1'b0;
    chk("R9 shared low", irq_shared, 1'b0);

    // R1 asynchronous reset while a request is active
    wr1[7:0] = 8'h01; wr15[7:0] = 8'h80; rr0[7:0] = 8'h80; nx(); nx();
    chk("R5 break before reset", ch_irq[0], 1'b1);
    #1 rst_n = 1'b0; #1;
    chk("R1 async reset", irq_shared, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule